// File: doc/BRIEF.md
# Output Sample-Spacing FIFO

This block sits after a filter engine that produces samples in bursts or with gaps. It re-emits those samples at an even pace. A programmable spacing value sets the minimum number of clocks between two outputs. A small FIFO of four entries absorbs bursts. A reloading down-counter decides when the next sample may leave. When the FIFO is empty and the counter has already run out, an arriving sample goes straight through to the output register.

The spacing input holds the desired spacing minus one. With a value of zero, samples leave one clock after arrival and no pacing takes place. The consumer always accepts, so there is no backpressure. A sample written while the FIFO is full, with no read in the same clock, is lost. The loss is recorded in a sticky overflow flag.

Top module: `sample_pacer`

## Requirements
- R1: After reset, `out_valid` and `overflow` are 0 and the FIFO is empty.
- R2: If the FIFO is empty and the pacing counter is at terminal count (zero), a sample presented with `in_valid` appears on `out_data` with `out_valid` high on the next clock.
- R3: A sample presented while the FIFO holds 4 samples and no sample leaves in that clock is dropped, and `overflow` goes to 1. `overflow` stays at 1 until reset.
- R4: Each time a sample is emitted, the counter reloads with `spacing`. The next emission is therefore at least `spacing`+1 clocks later, and exactly that many when data is waiting.
- R5: A sample that arrives while the counter is not at terminal count is held in the FIFO until the counter reaches zero.
- R6: When the counter reaches zero with the FIFO empty, it holds at zero, so the next arriving sample passes through at once, however long the idle time was.
- R7: Samples leave in arrival order, with at most one per clock.
- R8: The FIFO holds at most 4 samples. A dropped sample never appears on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Input sample |
| spacing | input | SPC_W | Desired output spacing in clocks, minus one |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DATA_W | Output sample |
| overflow | output | 1 | Sticky flag: a sample was dropped |

## Verification
The hardest situation to create from the ports is a write into a full FIFO. Two cases matter: the clock in which the counter expires, where the write must be kept, and the clock just before, where the write must be dropped. To reach the full state, the stimulus holds a large spacing value and sends a dense burst of six samples. Random phases then mix wide spacings with high arrival rates, so the full-with-simultaneous-read case also occurs. A reference model in the bench predicts every output clock.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    // Width of an index able to address n items, never below one bit.
    function automatic int unsigned idx_w(int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned PTR_W = sfifo_pkg::idx_w(DEPTH),
    localparam int unsigned LVL_W = sfifo_pkg::idx_w(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic [LVL_W-1:0]  level
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [LVL_W-1:0]             lvl;
    } store_t;

    store_t st_d, st_q;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = wdata;
            st_d.wr           = bump(st_q.wr);
        end
        if (pop) begin
            st_d.rd = bump(st_q.rd);
        end
        case ({push, pop})
            2'b10:   st_d.lvl = st_q.lvl + 1'b1;
            2'b01:   st_d.lvl = st_q.lvl - 1'b1;
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd];
    assign empty = (st_q.lvl == '0);
    assign full  = (st_q.lvl == LVL_W'(DEPTH));
    assign level = st_q.lvl;
endmodule

// File: rtl/sfifo_pacer.sv
module sfifo_pacer #(
    parameter int unsigned SPC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [SPC_W-1:0] spacing,
    output logic             expired,
    output logic [SPC_W-1:0] count
);
    logic [SPC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (fire)                cnt_d = spacing;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
    assign count   = cnt_q;
endmodule

// File: rtl/sample_pacer.sv
module sample_pacer #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SPC_W  = 8,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [SPC_W-1:0]  spacing,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              overflow
);
    localparam int unsigned LVL_W = sfifo_pkg::idx_w(DEPTH + 1);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
        logic              ovf;
    } out_t;

    out_t o_d, o_q;

    logic              q_empty, q_full, q_push, q_pop, fire, expired;
    logic [DATA_W-1:0] q_head;
    logic [LVL_W-1:0]  fill_lvl;
    logic [SPC_W-1:0]  timer_cnt;

    sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .pop   (q_pop),
        .wdata (in_data),
        .head  (q_head),
        .empty (q_empty),
        .full  (q_full),
        .level (fill_lvl)
    );

    sfifo_pacer #(.SPC_W(SPC_W)) pacer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .spacing (spacing),
        .expired (expired),
        .count   (timer_cnt)
    );

    always_comb begin
        fire   = expired && (!q_empty || in_valid);
        q_pop  = fire && !q_empty;
        // Straight pass-through when empty and expired; otherwise store if room.
        q_push = in_valid && !(fire && q_empty) && (!q_full || q_pop);
        o_d.vld = fire;
        o_d.dat = q_empty ? in_data : q_head;
        o_d.ovf = o_q.ovf || (in_valid && q_full && !q_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.vld;
    assign out_data  = o_q.dat;
    assign overflow  = o_q.ovf;
endmodule

// File: rtl/sample_pacer_chk.sv
module sample_pacer_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SPC_W  = 8,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned LVL_W = sfifo_pkg::idx_w(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [SPC_W-1:0]  spacing,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              overflow,
    input logic [SPC_W-1:0]  timer_cnt,
    input logic [LVL_W-1:0]  fill_lvl
);
    p_pass_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_cnt == '0 && fill_lvl == '0 && in_valid)
        |=> (out_valid && out_data == $past(in_data)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (timer_cnt == $past(spacing)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_cnt != '0) |=> !out_valid);

    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_cnt == '0 && fill_lvl == '0 && !in_valid) |=> (timer_cnt == '0 && !out_valid));

    p_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_lvl <= LVL_W'(DEPTH));
endmodule

bind sample_pacer sample_pacer_chk #(.DATA_W(DATA_W), .SPC_W(SPC_W), .DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .spacing   (spacing),
    .out_valid (out_valid),
    .out_data  (out_data),
    .overflow  (overflow),
    .timer_cnt (timer_cnt),
    .fill_lvl  (fill_lvl)
);

// File: tb/sample_pacer_tb.sv
module sample_pacer_tb_top;
    localparam int DW = 16;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [SW-1:0] spacing = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          overflow;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    // Reference state
    int m_q[$];
    int m_cnt = 0;
    bit m_ovf = 0;
    bit e_v;
    int e_d;

    always #2 clk = ~clk;

    sample_pacer #(.DATA_W(DW), .SPC_W(SW), .DEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .spacing(spacing), .out_valid(out_valid), .out_data(out_data), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic void model_reset();
        m_q.delete();
        m_cnt = 0;
        m_ovf = 0;
    endfunction

    // Expected behaviour for one clock, from the requirements.
    function automatic void model_step(input bit v, input int d, input int sp);
        int  sz  = m_q.size();
        bit  fr  = (m_cnt == 0) && (sz > 0 || v);
        bit  pop = fr && sz > 0;
        e_v = fr;
        e_d = fr ? (sz > 0 ? m_q[0] : d) : 0;
        if (pop) void'(m_q.pop_front());
        if (v && !(fr && sz == 0)) begin
            if (sz < 4 || pop) m_q.push_back(d);
            else m_ovf = 1;
        end
        m_cnt = fr ? sp : (m_cnt > 0 ? m_cnt - 1 : 0);
    endfunction

    // One clock: drive at negedge, compare just after posedge.
    task automatic tick(input bit v, input int d, output bit got_v, output int got_d);
        @(negedge clk);
        in_valid = v;
        in_data  = DW'(d);
        model_step(v, d, int'(spacing));
        @(posedge clk);
        #1;
        cyc++;
        got_v = out_valid;
        got_d = int'(out_data);
        check(out_valid == e_v, e_v ? "R4 emit timing" : "R5 hold", out_valid, e_v);
        if (e_v) check(int'(out_data) == e_d, "R7 order", out_data, e_d);
        check(overflow == m_ovf, "R3 overflow", overflow, m_ovf);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        check(overflow == 1'b0, "R1 reset overflow", overflow, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        bit gv;
        int gd;
        int seen;
        void'($urandom(32'd4711));
        do_reset();

        // R2: pass-through with spacing 0 (fall-through)
        spacing = 0;
        tick(1, 100, gv, gd);
        check(gv == 1 && gd == 100, "R2 pass-through", gd, 100);
        tick(1, 101, gv, gd);
        check(gv == 1 && gd == 101, "R2 fall-through back-to-back", gd, 101);
        tick(0, 0, gv, gd);

        // R6: long idle with spacing 3, then immediate pass-through
        spacing = 3;
        tick(1, 200, gv, gd);
        for (int i = 0; i < 20; i++) tick(0, 0, gv, gd);
        tick(1, 201, gv, gd);
        check(gv == 1 && gd == 201, "R6 idle hold then pass", gd, 201);

        // R4: burst of 3 with spacing 3 -> outputs 4 clocks apart
        for (int i = 0; i < 10; i++) tick(0, 0, gv, gd);
        begin
            int last = -1;
            int gaps_ok = 1;
            for (int i = 0; i < 30; i++) begin
                tick(i < 3, 300 + i, gv, gd);
                if (gv) begin
                    if (last >= 0 && (i - last) != 4) gaps_ok = 0;
                    last = i;
                end
            end
            check(gaps_ok == 1, "R4 spacing of four clocks", gaps_ok, 1);
        end

        // R3 / R8: burst of six with spacing 10 -> one through, four stored, one dropped
        spacing = 10;
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            tick(i < 6, 400 + i, gv, gd);
            if (gv) begin
                seen++;
                check(gd != 405, "R8 dropped sample absent", gd, 0);
            end
        end
        check(seen == 5, "R8 five of six delivered", seen, 5);
        check(overflow == 1, "R3 overflow set", overflow, 1);
        for (int i = 0; i < 5; i++) tick(0, 0, gv, gd);
        check(overflow == 1, "R3 overflow sticky", overflow, 1);

        do_reset();

        // Random phases
        for (int ph = 0; ph < 40; ph++) begin
            int rate = 1 + int'($urandom_range(0, 9));
            spacing = SW'($urandom_range(0, 6));
            for (int i = 0; i < 200; i++) begin
                bit v = ($urandom_range(0, 9) < rate);
                tick(v, int'($urandom_range(0, 65535)), gv, gd);
            end
            if (ph % 10 == 9) do_reset();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule